// File: doc/BRIEF.md
# Serial Disk Byte Transfer Engine

This block connects a CPU-side register port to a disk drive that has no controller of its own. The drive sees only a raw serial stream. All serialisation is done here, in one 8-bit shift register that works in one direction at a time. In read mode, bits arrive on `ser_in`, most significant bit first. Each completed byte is copied into a read-data register. In write mode, a byte is taken from the write-data register and shifted out on `ser_out`, most significant bit first. When that byte is done, the shift register reloads itself from the write-data register.

A bit period lasts `DIV` clock cycles and comes from a local divider. Bits move only while the motor bit, the start bit and the external I/O enable are all set. A single byte-done flag paces software in both directions. Software clears it by writing write-data, reading read-data or reading status. The same flag drives the interrupt output when the interrupt enable bit is set. Writing the transfer-reset bit in the control register restarts the divider and the bit counter. It also clears the flag and reloads the shift register from write-data.

Top module: `sdx_xfer_engine`

## Requirements
- R1: After reset, `rdata`, `irq`, `ser_out` and `mirror` are 0, and a read of the control register returns 0x20.
- R2: Register addresses are: 0 write-data (write), 1 control (read/write), 2 status (read), 3 read-data (read), 4 drive status (read). The control bits are: 0 motor, 1 transfer reset (one-shot, reads 0), 2 direction (1 read, 0 write), 3 mirroring, 4 CRC control, 5 constant 1 on read, 6 start, 7 interrupt enable. A read updates `rdata` at the clock edge where `rd_en` is sampled, using the values before that edge.
- R3: In read mode, after a control write that sets motor, start and transfer reset at edge E, bit k (k=0..7, MSB first) is sampled from `ser_in` at edge E+DIV*(k+1). At edge E+8*DIV the read-data register takes the byte and the flag sets.
- R4: In write mode, transfer reset loads the shift register from write-data. During bit period k, `ser_out` shows bit 7-k. At edge E+8*DIV the flag sets and the shift register reloads from write-data.
- R5: Unless motor and start are both 1, the bit counter and divider hold, the flag does not set, and status bit 7 reads 0.
- R6: The flag clears on a write to write-data, a read of read-data or a read of status. A status read returns the flag value from before the clear.
- R7: Status register: bit 1 is the flag, bit 4 is `crc_err`, bit 6 is `end_of_head`, and bit 7 is 1 when shifting is active and `not_ready` is 0. All other bits are 0.
- R8: Drive status register: bit 0 is `disk_absent`, bit 1 is `not_ready` and bit 2 is `write_prot`. All other bits are 0.
- R9: `irq` equals the flag while control bit 7 is 1, and is 0 otherwise.
- R10: While `io_enable` is 0, register writes are ignored, reads return 0 with no side effect, the flag is cleared and shifting stops.
- R11: `mirror` follows the stored control bit 3.
- R12: A transfer reset in the middle of a byte restarts counting from bit 0 and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| io_enable | input | 1 | Master disk I/O enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ser_in | input | 1 | Serial data from drive |
| ser_out | output | 1 | Serial data to drive |
| end_of_head | input | 1 | Head at inner track |
| crc_err | input | 1 | CRC error indication |
| disk_absent | input | 1 | No disk inserted |
| not_ready | input | 1 | Drive not ready |
| write_prot | input | 1 | Disk write protected |
| mirror | output | 1 | Stored mirroring bit |
| irq | output | 1 | Byte-done interrupt |

## Verification
A bit counter that is off by one shows up on the first byte. Either a rotated value appears in read-data, or `irq` rises one bit period early or late. Both are caught within 8*DIV cycles after a transfer reset. A divider or shift-register fault corrupts `ser_out` during the bit period where it happens. Every byte value is swept in both directions, so a stuck or swapped shift bit cannot hide. A flag-clear fault leaves `irq` high on the very next sampled cycle after the clearing access.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  localparam logic [2:0] A_WDATA = 3'd0;
  localparam logic [2:0] A_CTRL  = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_RDATA = 3'd3;
  localparam logic [2:0] A_DRIVE = 3'd4;

  // control bit positions
  localparam int C_MOTOR  = 0;
  localparam int C_XRST   = 1;
  localparam int C_DIR    = 2;
  localparam int C_MIRROR = 3;
  localparam int C_CRC    = 4;
  localparam int C_START  = 6;
  localparam int C_IEN    = 7;

  typedef struct packed {
    logic irq_en;
    logic start;
    logic crc_ctl;
    logic mirror;
    logic dir_rd;
    logic motor;
  } sdx_ctrl_t;
endpackage

// File: rtl/sdx_bitclk.sv
module sdx_bitclk #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdx_shifter.sv
module sdx_shifter #(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic          dir_rd,
  input  logic          ser_in,
  input  logic [W-1:0]  load_byte,
  output logic          ser_out,
  output logic          byte_done,
  output logic [W-1:0]  rx_byte,
  output logic [$clog2(W)-1:0] bit_cnt
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LASTBIT = BW'(W - 1);

  logic [W-1:0] sh;
  logic         last;

  assign last      = (bit_cnt == LASTBIT);
  assign byte_done = tick && last && !restart;
  assign rx_byte   = {sh[W-2:0], ser_in};
  assign ser_out   = !dir_rd && sh[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (restart) begin
      sh      <= load_byte;
      bit_cnt <= '0;
    end else if (tick) begin
      bit_cnt <= last ? '0 : bit_cnt + 1'b1;
      if (dir_rd) begin
        sh <= {sh[W-2:0], ser_in};
      end else begin
        sh <= last ? load_byte : {sh[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sdx_xfer_engine.sv
module sdx_xfer_engine
  import sdx_pkg::*;
#(
  parameter int DIV = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_enable,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ser_in,
  output logic          ser_out,
  input  logic          end_of_head,
  input  logic          crc_err,
  input  logic          disk_absent,
  input  logic          not_ready,
  input  logic          write_prot,
  output logic          mirror,
  output logic          irq
);
  localparam int BW = $clog2(DW);

  sdx_ctrl_t      ctrl_q;
  logic [DW-1:0]  wbuf_q;
  logic [DW-1:0]  rbuf_q;
  logic           flag_q;
  logic           run;
  logic           tick;
  logic           byte_done;
  logic [DW-1:0]  rx_byte;
  logic [BW-1:0]  bit_cnt;
  logic           acc_wr;
  logic           acc_rd;
  logic           wr_ctrl;
  logic           xreset;
  logic           flag_clr;
  logic [DW-1:0]  ctrl_rb;
  logic [DW-1:0]  stat_rb;
  logic [DW-1:0]  drv_rb;
  logic [DW-1:0]  rd_mux;

  assign acc_wr  = wr_en && io_enable;
  assign acc_rd  = rd_en && io_enable;
  assign wr_ctrl = acc_wr && (addr == A_CTRL);
  assign xreset  = wr_ctrl && wdata[C_XRST];
  assign run     = io_enable && ctrl_q.motor && ctrl_q.start;

  assign flag_clr = (acc_wr && (addr == A_WDATA))
                 || (acc_rd && ((addr == A_RDATA) || (addr == A_STAT)))
                 || xreset;

  sdx_bitclk #(.DIV(DIV)) u_bitclk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (xreset),
    .tick    (tick)
  );

  sdx_shifter #(.W(DW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .restart   (xreset),
    .dir_rd    (ctrl_q.dir_rd),
    .ser_in    (ser_in),
    .load_byte (wbuf_q),
    .ser_out   (ser_out),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .bit_cnt   (bit_cnt)
  );

  // control and data registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      wbuf_q <= '0;
      rbuf_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.motor   <= wdata[C_MOTOR];
        ctrl_q.dir_rd  <= wdata[C_DIR];
        ctrl_q.mirror  <= wdata[C_MIRROR];
        ctrl_q.crc_ctl <= wdata[C_CRC];
        ctrl_q.start   <= wdata[C_START];
        ctrl_q.irq_en  <= wdata[C_IEN];
      end
      if (acc_wr && (addr == A_WDATA)) begin
        wbuf_q <= wdata;
      end
      if (byte_done && ctrl_q.dir_rd) begin
        rbuf_q <= rx_byte;
      end
    end
  end

  // byte-done flag: a completed byte wins over a clearing access
  always_ff @(posedge clk) begin
    if (rst || !io_enable) begin
      flag_q <= 1'b0;
    end else if (byte_done) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

  assign ctrl_rb = {ctrl_q.irq_en, ctrl_q.start, 1'b1, ctrl_q.crc_ctl,
                    ctrl_q.mirror, ctrl_q.dir_rd, 1'b0, ctrl_q.motor};
  assign stat_rb = {run && !not_ready, end_of_head, 1'b0, crc_err,
                    2'b00, flag_q, 1'b0};
  assign drv_rb  = {{(DW-3){1'b0}}, write_prot, not_ready, disk_absent};

  always_comb begin
    case (addr)
      A_CTRL:  rd_mux = ctrl_rb;
      A_STAT:  rd_mux = stat_rb;
      A_RDATA: rd_mux = rbuf_q;
      A_DRIVE: rd_mux = drv_rb;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= io_enable ? rd_mux : '0;
    end
  end

  assign mirror = ctrl_q.mirror;
  assign irq    = flag_q && ctrl_q.irq_en;
endmodule

// File: rtl/sdx_xfer_checks.sv
module sdx_xfer_checks #(
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          io_enable,
  input logic          rd_en,
  input logic [2:0]    addr,
  input logic [7:0]    rdata,
  input logic          irq,
  input logic          flag_q,
  input logic          run,
  input logic          xreset,
  input logic          byte_done,
  input logic          wr_en,
  input logic [BW-1:0] bit_cnt,
  input logic [7:0]    ctrl_rb
);
  p_flag_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(run));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !xreset) |=> $stable(bit_cnt));

  p_rd_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && io_enable && addr == 3'd3 && !byte_done) |=> !flag_q);

  p_quiet_off_r10: assert property (@(posedge clk) disable iff (rst)
    !io_enable |=> (!irq && !flag_q));

  p_wr_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !io_enable) |=> $stable(ctrl_rb));

  p_bit5_set_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && io_enable && addr == 3'd1) |=> rdata[5]);
endmodule

bind sdx_xfer_engine sdx_xfer_checks #(.BW(BW)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .io_enable (io_enable),
  .rd_en     (rd_en),
  .addr      (addr),
  .rdata     (rdata),
  .irq       (irq),
  .flag_q    (flag_q),
  .run       (run),
  .xreset    (xreset),
  .byte_done (byte_done),
  .wr_en     (wr_en),
  .bit_cnt   (bit_cnt),
  .ctrl_rb   (ctrl_rb)
);

// File: tb/tb_sdx_xfer_engine.sv
module tb_sdx_xfer_engine;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_enable = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ser_in = 1'b0;
  logic       ser_out;
  logic       end_of_head = 1'b0;
  logic       crc_err = 1'b0;
  logic       disk_absent = 1'b0;
  logic       not_ready = 1'b0;
  logic       write_prot = 1'b0;
  logic       mirror;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdx_xfer_engine #(.DIV(DIV), .DW(8)) dut (
    .clk(clk), .rst(rst), .io_enable(io_enable), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ser_in(ser_in), .ser_out(ser_out),
    .end_of_head(end_of_head), .crc_err(crc_err), .disk_absent(disk_absent),
    .not_ready(not_ready), .write_prot(write_prot), .mirror(mirror), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(rdata === 8'h00, "R1 rdata", rdata, 0);
    chk(irq === 1'b0, "R1 irq", irq, 0);
    chk(ser_out === 1'b0, "R1 ser_out", ser_out, 0);
    chk(mirror === 1'b0, "R1 mirror", mirror, 0);
    rd(3'd1, d);
    chk(d === 8'h20, "R1 ctrl", d, 8'h20);

    // R11 / R2 mirror and control readback
    wr(3'd1, 8'h08);
    chk(mirror === 1'b1, "R11 mirror set", mirror, 1);
    rd(3'd1, d);
    chk(d === 8'h28, "R2 ctrl readback", d, 8'h28);
    wr(3'd1, 8'h00);
    chk(mirror === 1'b0, "R11 mirror clr", mirror, 0);

    // R8 drive status sweep
    for (int m = 0; m < 8; m++) begin
      disk_absent = m[0]; not_ready = m[1]; write_prot = m[2];
      rd(3'd4, d);
      chk(d === 8'(m), "R8 drive status", d, m);
    end
    disk_absent = 0; not_ready = 0; write_prot = 0;

    // R7 status sweep while shifting active and while idle
    for (int act = 0; act < 2; act++) begin
      wr(3'd1, act ? 8'hC7 : 8'h86);
      for (int m = 0; m < 8; m++) begin
        end_of_head = m[0]; crc_err = m[1]; not_ready = m[2];
        rd(3'd2, d);
        chk(d === {(act == 1) && !m[2], m[0], 1'b0, m[1], 4'b0000},
            "R7 status", d, {(act == 1) && !m[2], m[0], 1'b0, m[1], 4'b0000});
      end
    end
    end_of_head = 0; crc_err = 0; not_ready = 0;

    // R3 read sweep, R6 read-data clear
    for (int v = 0; v < 256; v++) begin
      wr(3'd1, 8'hC7);
      for (int k = 0; k < 8; k++) begin
        ser_in = v[7-k];
        if (k == 7) chk(irq === 1'b0, "R3 early flag", irq, 0);
        repeat (DIV) @(negedge clk);
      end
      chk(irq === 1'b1, "R3 flag at byte end", irq, 1);
      rd(3'd3, d);
      chk(d === v[7:0], "R3 read byte", d, v);
      chk(irq === 1'b0, "R6 cleared by read-data", irq, 0);
    end

    // R4 write sweep, R6 write-data clear
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, v[7:0]);
      wr(3'd1, 8'hC3);
      for (int k = 0; k < 8; k++) begin
        chk(ser_out === v[7-k], "R4 serial bit", ser_out, v[7-k]);
        repeat (DIV) @(negedge clk);
      end
      chk(irq === 1'b1, "R4 flag at byte end", irq, 1);
      chk(ser_out === v[7], "R4 reload", ser_out, v[7]);
      wr(3'd0, 8'h00);
      chk(irq === 1'b0, "R6 cleared by write-data", irq, 0);
    end

    // R12 mid-byte restart, then flag cleared by transfer reset
    wr(3'd1, 8'hC7);
    ser_in = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    wr(3'd1, 8'hC7);
    for (int k = 0; k < 8; k++) begin
      ser_in = 8'h5A >> (7 - k);
      repeat (DIV) @(negedge clk);
    end
    chk(irq === 1'b1, "R12 flag after restart", irq, 1);
    rd(3'd3, d);
    chk(d === 8'h5A, "R12 byte after restart", d, 8'h5A);
    wr(3'd1, 8'hC7);
    for (int k = 0; k < 8; k++) begin
      repeat (DIV) @(negedge clk);
    end
    chk(irq === 1'b1, "R12 flag set again", irq, 1);
    wr(3'd1, 8'hC7);
    chk(irq === 1'b0, "R12 cleared by transfer reset", irq, 0);

    // R5 no shifting without motor or without start
    for (int c = 0; c < 2; c++) begin
      wr(3'd1, c ? 8'h46 : 8'h07);
      repeat (12 * DIV) @(negedge clk);
      rd(3'd2, d);
      chk(d[1] === 1'b0, "R5 flag idle", d[1], 0);
      chk(d[7] === 1'b0, "R5 not active", d[7], 0);
    end

    // R9 interrupt disabled, R6 status-read clear
    wr(3'd1, 8'h47);
    repeat (8 * DIV) @(negedge clk);
    chk(irq === 1'b0, "R9 irq masked", irq, 0);
    rd(3'd2, d);
    chk(d[1] === 1'b1, "R9 flag visible", d[1], 1);
    rd(3'd2, d);
    chk(d[1] === 1'b0, "R6 cleared by status read", d[1], 0);

    // R10 disabled engine
    repeat (8 * DIV) @(negedge clk);
    io_enable = 1'b0;
    @(negedge clk);
    wr(3'd1, 8'h08);
    chk(mirror === 1'b0, "R10 write ignored", mirror, 0);
    rd(3'd1, d);
    chk(d === 8'h00, "R10 read zero", d, 0);
    io_enable = 1'b1;
    rd(3'd1, d);
    chk(d === 8'h65, "R10 ctrl kept", d, 8'h65);
    rd(3'd2, d);
    chk(d[1] === 1'b0, "R10 flag cleared", d[1], 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule